// File: doc/BRIEF.md
# Duty-Ratio Best-Fit Search Engine

This block picks the ON and OFF counts for a suspend-style clock throttler. Software hands it a target rate and the unthrottled rate, both in kHz, and asks for the pair of 8-bit counts whose modulated rate, full × OFF / (ON + OFF), comes nearest the target. One start pulse runs an exhaustive search. The search walks the total period from a programmable maximum down to one. For every period it runs two divisions on a shared restoring divider. The first gives the OFF count. The second gives the rate that OFF count achieves.

Each candidate's distance from the target is compared against the best so far. A candidate that is as close or closer replaces the stored pair. Because the walk descends, ties go to the shorter period, which gives lower modulation latency. At the end the block presents the chosen pair and the rate it yields, and raises a one-cycle done pulse.

Top module: `duty_fit_search`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are low and on_cnt, off_cnt and rate_khz are zero until the first search completes.
- R2: A start seen while busy is low sets busy on the next cycle. Busy stays high until the cycle in which done is high. Done lasts exactly one cycle, and busy is low in that cycle.
- R3: The search covers every period i from max_dur down to 1, where max_dur is an 8-bit count. A max_dur of 0 behaves exactly like 1.
- R4: For period i the candidate OFF count is floor(target × i / full) taken modulo 256. The candidate ON count is (i − OFF) modulo 256.
- R5: The candidate rate is floor(full × OFF / i), computed without overflow. Its error is |rate − target| at full precision. rate_khz reports the low 32 bits of the chosen rate.
- R6: A candidate replaces the stored best when its error is less than or equal to the stored error. Equal errors therefore resolve to the smallest period.
- R7: Before the first candidate is weighed, the stored best is OFF = 1, ON = 0 and rate = full. It survives when no candidate comes as close.
- R8: A start that arrives while busy is high is ignored. The running search finishes with its original operands.
- R9: After done, on_cnt, off_cnt and rate_khz hold their values until the next accepted start.
- R10: target_khz, full_khz and max_dur are sampled only on an accepted start. Changing them during a search has no effect on its result. full_khz must be non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| target_khz | input | 32 | Requested rate in kHz |
| full_khz | input | 32 | Unthrottled rate in kHz, non-zero |
| max_dur | input | 8 | Longest total period to try (0 means 1) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| on_cnt | output | 8 | Chosen ON (suspended) count |
| off_cnt | output | 8 | Chosen OFF (running) count |
| rate_khz | output | 32 | Rate achieved by the chosen pair |

## Verification
A divider that drops or shifts a quotient bit shows up as a wrong OFF count, or as a rate that misses floor(full × OFF / i). It is visible at the very next done pulse. A fault in the comparison or the tie rule moves the chosen pair to a different period. The tie cases are chosen so that a strict less-than, or a keep-first policy, lands on a visibly different OFF count. A controller that skips or repeats a period, or mishandles a max_dur of zero, changes the pair or the done timing. A stuck busy flag leaves done missing until the per-search timeout fires.

// File: rtl/duty_fit_pkg.sv
package duty_fit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFF  = 2'd1,
    ST_RATE = 2'd2,
    ST_CMP  = 2'd3
  } fit_state_e;
endpackage

// File: rtl/duty_fit_div.sv
module duty_fit_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             fin,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, rem_d, dvs_q, dvs_d;
  logic [NUM_W-1:0] qd_q, qd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             run_q, run_d, fin_q, fin_d;
  logic [DEN_W:0]   rem_sh, diff;
  logic             ge;

  always_comb begin
    rem_sh = {rem_q, qd_q[NUM_W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    ge     = (rem_sh >= {1'b0, dvs_q});
    rem_d  = rem_q;
    qd_d   = qd_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d = '0;
      qd_d  = dividend;
      dvs_d = divisor;
      cnt_d = CW'(NUM_W);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
      qd_d  = {qd_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      qd_q  <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      qd_q  <= qd_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign fin  = fin_q;
  assign quot = qd_q;
endmodule

// File: rtl/duty_fit_pick.sv
module duty_fit_pick #(
  parameter int RATE_W = 40,
  parameter int FREQ_W = 32
) (
  input  logic [RATE_W-1:0] cand_rate,
  input  logic [FREQ_W-1:0] target,
  input  logic [RATE_W-1:0] best_err,
  output logic [RATE_W-1:0] cand_err,
  output logic              take
);
  logic [RATE_W-1:0] tgt_ext;

  always_comb begin
    tgt_ext  = RATE_W'(target);
    cand_err = (cand_rate >= tgt_ext) ? (cand_rate - tgt_ext) : (tgt_ext - cand_rate);
    take     = (cand_err <= best_err);
  end
endmodule

// File: rtl/duty_fit_search.sv
module duty_fit_search
  import duty_fit_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int CNT_W     = 8,
  parameter int MAX_LIMIT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] target_khz,
  input  logic [FREQ_W-1:0] full_khz,
  input  logic [CNT_W-1:0]  max_dur,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  on_cnt,
  output logic [CNT_W-1:0]  off_cnt,
  output logic [FREQ_W-1:0] rate_khz
);
  localparam int PROD_W = FREQ_W + CNT_W;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LIMIT);

  fit_state_e        state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d, offc_q, offc_d;
  logic [CNT_W-1:0]  bon_q, bon_d, boff_q, boff_d;
  logic [FREQ_W-1:0] tgt_q, tgt_d, full_q, full_d;
  logic [PROD_W-1:0] ratec_q, ratec_d, brate_q, brate_d, berr_q, berr_d;
  logic              go_q, go_d, busy_q, busy_d, done_q, done_d;

  logic [PROD_W-1:0] div_num, div_quot, cand_err;
  logic [FREQ_W-1:0] div_den;
  logic              div_fin, take;
  logic [CNT_W-1:0]  first_idx;
  logic [PROD_W-1:0] init_err;

  always_comb begin
    if (max_dur == '0)        first_idx = CNT_W'(1);
    else if (max_dur > LIMIT) first_idx = LIMIT;
    else                      first_idx = max_dur;
    init_err = (full_khz >= target_khz) ? PROD_W'(full_khz - target_khz)
                                        : PROD_W'(target_khz - full_khz);
  end

  always_comb begin
    if (state_q == ST_RATE) begin
      div_num = PROD_W'(full_q) * PROD_W'(offc_q);
      div_den = FREQ_W'(idx_q);
    end else begin
      div_num = PROD_W'(tgt_q) * PROD_W'(idx_q);
      div_den = full_q;
    end
  end

  duty_fit_div #(.NUM_W(PROD_W), .DEN_W(FREQ_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go_q), .dividend(div_num),
    .divisor(div_den), .fin(div_fin), .quot(div_quot)
  );

  duty_fit_pick #(.RATE_W(PROD_W), .FREQ_W(FREQ_W)) u_pick (
    .cand_rate(ratec_q), .target(tgt_q), .best_err(berr_q),
    .cand_err(cand_err), .take(take)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    offc_d  = offc_q;
    ratec_d = ratec_q;
    tgt_d   = tgt_q;
    full_d  = full_q;
    bon_d   = bon_q;
    boff_d  = boff_q;
    brate_d = brate_q;
    berr_d  = berr_q;
    go_d    = 1'b0;
    busy_d  = busy_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        tgt_d   = target_khz;
        full_d  = full_khz;
        idx_d   = first_idx;
        boff_d  = CNT_W'(1);
        bon_d   = '0;
        brate_d = PROD_W'(full_khz);
        berr_d  = init_err;
        go_d    = 1'b1;
        busy_d  = 1'b1;
        state_d = ST_OFF;
      end
      ST_OFF: if (div_fin) begin
        offc_d  = div_quot[CNT_W-1:0];
        go_d    = 1'b1;
        state_d = ST_RATE;
      end
      ST_RATE: if (div_fin) begin
        ratec_d = div_quot;
        state_d = ST_CMP;
      end
      ST_CMP: begin
        if (take) begin
          boff_d  = offc_q;
          bon_d   = idx_q - offc_q;
          brate_d = ratec_q;
          berr_d  = cand_err;
        end
        if (idx_q == CNT_W'(1)) begin
          busy_d  = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          idx_d   = idx_q - 1'b1;
          go_d    = 1'b1;
          state_d = ST_OFF;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      offc_q  <= '0;
      ratec_q <= '0;
      tgt_q   <= '0;
      full_q  <= '0;
      bon_q   <= '0;
      boff_q  <= '0;
      brate_q <= '0;
      berr_q  <= '0;
      go_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      offc_q  <= offc_d;
      ratec_q <= ratec_d;
      tgt_q   <= tgt_d;
      full_q  <= full_d;
      bon_q   <= bon_d;
      boff_q  <= boff_d;
      brate_q <= brate_d;
      berr_q  <= berr_d;
      go_q    <= go_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign on_cnt   = bon_q;
  assign off_cnt  = boff_q;
  assign rate_khz = brate_q[FREQ_W-1:0];
endmodule

// File: rtl/duty_fit_sva.sv
module duty_fit_sva #(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  on_cnt,
  input logic [CNT_W-1:0]  off_cnt,
  input logic [FREQ_W-1:0] rate_khz
);
  logic [CNT_W-1:0] pair_sum;
  assign pair_sum = on_cnt + off_cnt;

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pair_sum != '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(on_cnt) && $stable(off_cnt) && $stable(rate_khz)));
endmodule

bind duty_fit_search duty_fit_sva #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .on_cnt(on_cnt), .off_cnt(off_cnt), .rate_khz(rate_khz)
);

// File: tb/tb_duty_fit_search.sv
module tb_duty_fit_search;
  logic        clk, rst_n, start;
  logic [31:0] target_khz, full_khz;
  logic [7:0]  max_dur;
  logic        busy, done;
  logic [7:0]  on_cnt, off_cnt;
  logic [31:0] rate_khz;

  int checks = 0;
  int errors = 0;

  duty_fit_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .full_khz(full_khz), .max_dur(max_dur), .busy(busy), .done(done),
    .on_cnt(on_cnt), .off_cnt(off_cnt), .rate_khz(rate_khz)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned absd(input longint unsigned a, input longint unsigned b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic model(input longint unsigned t, input longint unsigned f, input int m,
                       output int e_on, output int e_off, output longint unsigned e_rate);
    int mm;
    longint unsigned berr;
    mm = (m == 0) ? 1 : m;
    e_off = 1; e_on = 0; e_rate = f; berr = absd(f, t);
    for (int i = mm; i >= 1; i--) begin
      longint unsigned o, r, e;
      o = ((t * longint'(i)) / f) % 256;
      r = (f * o) / longint'(i);
      e = absd(r, t);
      if (e <= berr) begin
        e_off = int'(o);
        e_on = (i + 256 - int'(o)) % 256;
        e_rate = r;
        berr = e;
      end
    end
  endtask

  task automatic pulse_start(input logic [31:0] t, input logic [31:0] f, input logic [7:0] m);
    target_khz = t; full_khz = f; max_dur = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit ok);
    int n;
    n = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 30000) begin
        errors++;
        $display("FAIL %s timeout: actual=no done expected=done", req);
        ok = 1'b0;
        return;
      end
    end
  endtask

  task automatic run(input logic [31:0] t, input logic [31:0] f, input logic [7:0] m, input string req);
    int e_on, e_off;
    longint unsigned e_rate;
    bit ok;
    model(t, f, m, e_on, e_off, e_rate);
    pulse_start(t, f, m);
    chk({"R2 busy after start ", req}, busy, 1);
    wait_done(req, ok);
    if (!ok) return;
    chk({"R2 busy low at done ", req}, busy, 0);
    chk({"R4 off ", req}, off_cnt, e_off);
    chk({"R4 on ", req}, on_cnt, e_on);
    chk({"R5 rate ", req}, rate_khz, e_rate & 64'hFFFF_FFFF);
    @(negedge clk);
    chk({"R2 done single cycle ", req}, done, 0);
  endtask

  initial begin
    int e_on, e_off;
    longint unsigned e_rate;
    bit ok;
    logic [7:0] s_on, s_off;
    logic [31:0] s_rate;
    rst_n = 1'b0; start = 1'b0; target_khz = '0; full_khz = 32'd1; max_dur = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 off in reset", off_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 on after reset", on_cnt, 0);
    chk("R1 rate after reset", rate_khz, 0);

    run(32'd700, 32'd1000, 8'd1, "R7 initial pair kept");
    chk("R7 off is one", off_cnt, 1);
    run(32'd1000, 32'd1000, 8'd3, "R6 tie shortest period");
    chk("R6 off shortest", off_cnt, 1);
    run(32'd500, 32'd1000, 8'd4, "R6 tie at period two");
    chk("R6 off at period two", off_cnt, 1);
    chk("R6 on at period two", on_cnt, 1);
    run(32'd500, 32'd1000, 8'd0, "R3 zero max");
    chk("R3 zero max off", off_cnt, 0);
    chk("R3 zero max on", on_cnt, 1);
    run(32'd1500, 32'd1000, 8'd7, "R4 target above full");

    for (int mi = 0; mi < 4; mi++) begin
      for (int t = 0; t <= 1000; t += 97) begin
        logic [7:0] m;
        m = (mi == 0) ? 8'd0 : (mi == 1) ? 8'd1 : (mi == 2) ? 8'd5 : 8'd13;
        run(32'(t), 32'd1000, m, "R3 R5 sweep");
      end
    end

    run(32'd33333, 32'd200000, 8'd255, "R3 full length");
    run(32'd4_000_000, 32'd4_000_003, 8'd255, "R5 wide operands");

    // R8 and R10: operands changed and start re-pulsed during a search
    model(64'd300, 64'd1000, 9, e_on, e_off, e_rate);
    pulse_start(32'd300, 32'd1000, 8'd9);
    repeat (20) @(negedge clk);
    target_khz = 32'd900; full_khz = 32'd77; max_dur = 8'd3;
    repeat (20) @(negedge clk);
    pulse_start(32'd50, 32'd60, 8'd2);
    wait_done("R8", ok);
    chk("R8 off ignores late start", off_cnt, e_off);
    chk("R10 on unaffected by input change", on_cnt, e_on);
    chk("R10 rate unaffected by input change", rate_khz, e_rate);
    @(negedge clk);
    chk("R8 no second search", busy, 0);

    // R9: results hold while idle
    s_on = on_cnt; s_off = off_cnt; s_rate = rate_khz;
    target_khz = 32'd12; full_khz = 32'd99; max_dur = 8'd40;
    repeat (15) @(negedge clk);
    chk("R9 on held", on_cnt, s_on);
    chk("R9 off held", off_cnt, s_off);
    chk("R9 rate held", rate_khz, s_rate);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule